// File: doc/BRIEF.md
# Plug-and-Play Logical Device Register Bank

This block holds the resource settings of up to eight logical devices that live inside a multi-function I/O controller. Configuration software reaches the bank through three byte-wide host ports. One port takes a register number. One port writes a value into the numbered register. The third port returns the value of the numbered register. A selector register picks the logical device, and the per-device registers (enable, base address, interrupt line, DMA channel) are banked behind it. The same register numbers therefore reach a different device's settings depending on the selector.

The bank presents every device's settings on flat output buses, together with an active bit per device. When a write really changes a stored setting, the bank raises a one-cycle reconfigure pulse for that device, so the attached peripheral can re-map itself. The host ports answer only while the enable input from the configuration lock logic is high.

Top module: `pnp_ldev_bank`

## Requirements
- R1: A write to host address 0x0279 loads the register number. A write to address 0x0A79 writes the numbered register. A read at address 0x03E3 returns the numbered register. An access at any other address changes nothing, and busRdData is 0xFF whenever no enabled read of 0x03E3 is in progress.
- R2: While cfgEnable is low, writes at every address are ignored and busRdData is 0xFF.
- R3: Register 0x07 is the device selector. A write keeps only bits 2:0 of the value, and a read returns the selected device number with bits 7:3 zero.
- R4: For the selected device, register 0x30 is the enable byte, 0x60 is bits 15:8 of the base address, 0x61 is bits 7:0 of the base address, 0x70 is the IRQ and 0x74 is the DMA channel. Each is read back unchanged and appears on that device's slice of the output buses (device d occupies bits 8d+7:8d of the byte buses and bits 16d+15:16d of devBaseFlat).
- R5: A read of any register number other than 0x07, 0x30, 0x60, 0x61, 0x70 or 0x74 returns 0xFF, and a write to such a register has no effect.
- R6: After reset the settings are as follows. Device 0 (floppy): enable 0x01, base 0x03F0, IRQ 6, DMA 2. Device 1 (serial A): enable 0x01, base 0x03F8, IRQ 4. Device 2 (serial B): enable 0x01, base 0x02F8, IRQ 3. Device 3 (parallel): enable 0x01, base 0x0378, IRQ 7. Every other field of every device is zero.
- R7: For devices 1, 2 and 3, a write that changes the stored value of any of the five per-device registers raises that device's reconfigurePulse bit. A write of the value already stored raises nothing.
- R8: For device 0, only a change of its enable register raises reconfigurePulse bit 0. Writes to its base, IRQ or DMA registers never raise it.
- R9: Devices 4 to 7 and selector writes never raise a reconfigure pulse. Any pulse is high for exactly the one cycle that follows the clock edge that captured the data write.
- R10: devActive bit d equals bit 0 of device d's enable register.
- R11: Reset sets both the register number and the device selector to zero. Before any register number is written, reads return 0xFF and data writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Port access enable from the lock logic |
| busAddr | input | 16 | Host I/O address |
| busWrData | input | 8 | Host write data |
| busWr | input | 1 | Host write strobe, sampled at the clock edge |
| busRd | input | 1 | Host read strobe, read data is combinational |
| busRdData | output | 8 | Host read data |
| devActive | output | NUM_DEV | Bit 0 of each device's enable register |
| devEnableFlat | output | 8*NUM_DEV | Enable bytes of all devices |
| devBaseFlat | output | 16*NUM_DEV | Base addresses of all devices |
| devIrqFlat | output | 8*NUM_DEV | IRQ bytes of all devices |
| devDmaFlat | output | 8*NUM_DEV | DMA bytes of all devices |
| reconfigurePulse | output | NUM_DEV | One-cycle per-device setting-change pulse |

## Verification
The hardest situation to reach is a write whose outcome depends on three pieces of hidden state at once: the register number, the selected device, and the value already stored in that device's field. From the ports, it takes a selector write, a register-number write and a data write that either equals or differs from the stored byte. The random stimulus reaches this by biasing a third of its data writes toward the value the bench model currently holds, so that no-change writes happen often. It also cycles the selector through all eight devices and the register number through the known fields. Directed cases cover the device-0 rule, the low-bit masking of the selector, writes made while locked, and accesses at stray addresses.

// File: rtl/pnp_bank_pkg.sv
package pnp_bank_pkg;

  localparam logic [15:0] PORT_INDEX = 16'h0279;
  localparam logic [15:0] PORT_WDATA = 16'h0A79;
  localparam logic [15:0] PORT_RDATA = 16'h03E3;

  localparam logic [7:0] REG_SELECT = 8'h07;
  localparam logic [7:0] REG_ENABLE = 8'h30;
  localparam logic [7:0] REG_BASEHI = 8'h60;
  localparam logic [7:0] REG_BASELO = 8'h61;
  localparam logic [7:0] REG_IRQ    = 8'h70;
  localparam logic [7:0] REG_DMA    = 8'h74;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_SEL, FLD_EN, FLD_BHI, FLD_BLO, FLD_IRQ, FLD_DMA
  } fieldT;

  // control to datapath strobes
  typedef struct packed {
    logic       dataWr;
    logic       rdEn;
    fieldT      field;
    logic [7:0] wrData;
  } ctrlStrobeT;

  function automatic fieldT decodeField(input logic [7:0] idx);
    case (idx)
      REG_SELECT: return FLD_SEL;
      REG_ENABLE: return FLD_EN;
      REG_BASEHI: return FLD_BHI;
      REG_BASELO: return FLD_BLO;
      REG_IRQ:    return FLD_IRQ;
      REG_DMA:    return FLD_DMA;
      default:    return FLD_NONE;
    endcase
  endfunction

  // power-on resource map
  function automatic logic [7:0] defEnable(input int dev);
    return (dev <= 3) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [15:0] defBase(input int dev);
    case (dev)
      0:       return 16'h03F0;
      1:       return 16'h03F8;
      2:       return 16'h02F8;
      3:       return 16'h0378;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [7:0] defIrq(input int dev);
    case (dev)
      0:       return 8'd6;
      1:       return 8'd4;
      2:       return 8'd3;
      3:       return 8'd7;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] defDma(input int dev);
    return (dev == 0) ? 8'd2 : 8'd0;
  endfunction

  // which devices pulse on any field change, which only on enable change
  function automatic logic pulsesOnAny(input int dev);
    return (dev >= 1) && (dev <= 3);
  endfunction

  function automatic logic pulsesOnEnable(input int dev);
    return dev == 0;
  endfunction

endpackage

// File: rtl/pnp_bank_ctrl.sv
module pnp_bank_ctrl
  import pnp_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  logic [15:0] busAddr,
  input  logic [7:0]  busWrData,
  input  logic        busWr,
  input  logic        busRd,
  output ctrlStrobeT  strb
);
  logic [7:0] regIdx;
  logic       idxWr;

  assign idxWr = cfgEnable && busWr && (busAddr == PORT_INDEX);

  always_ff @(posedge clk) begin
    if (!rstN)      regIdx <= 8'h00;
    else if (idxWr) regIdx <= busWrData;
  end

  always_comb begin
    strb.dataWr = cfgEnable && busWr && (busAddr == PORT_WDATA);
    strb.rdEn   = cfgEnable && busRd && (busAddr == PORT_RDATA);
    strb.field  = decodeField(regIdx);
    strb.wrData = busWrData;
  end
endmodule

// File: rtl/pnp_bank_dp.sv
module pnp_bank_dp
  import pnp_bank_pkg::*;
#(
  parameter int NUM_DEV = 8,
  localparam int SEL_W  = $clog2(NUM_DEV)
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strb,
  output logic [7:0]             busRdData,
  output logic [NUM_DEV-1:0]     devActive,
  output logic [8*NUM_DEV-1:0]   devEnableFlat,
  output logic [16*NUM_DEV-1:0]  devBaseFlat,
  output logic [8*NUM_DEV-1:0]   devIrqFlat,
  output logic [8*NUM_DEV-1:0]   devDmaFlat,
  output logic [NUM_DEV-1:0]     reconfigurePulse
);
  logic [SEL_W-1:0] devSel;
  logic [7:0]       enR   [NUM_DEV];
  logic [15:0]      baseR [NUM_DEV];
  logic [7:0]       irqR  [NUM_DEV];
  logic [7:0]       dmaR  [NUM_DEV];
  logic [7:0]       curVal;
  logic             devField;
  logic [NUM_DEV-1:0] pulseNext;

  // value of the addressed register for the selected device
  always_comb begin
    case (strb.field)
      FLD_SEL: curVal = {{(8-SEL_W){1'b0}}, devSel};
      FLD_EN:  curVal = enR[devSel];
      FLD_BHI: curVal = baseR[devSel][15:8];
      FLD_BLO: curVal = baseR[devSel][7:0];
      FLD_IRQ: curVal = irqR[devSel];
      FLD_DMA: curVal = dmaR[devSel];
      default: curVal = 8'hFF;
    endcase
  end

  assign busRdData = strb.rdEn ? curVal : 8'hFF;
  assign devField  = (strb.field != FLD_NONE) && (strb.field != FLD_SEL);

  always_comb begin
    for (int d = 0; d < NUM_DEV; d++) begin
      pulseNext[d] = strb.dataWr && devField && (devSel == SEL_W'(d)) &&
                     (curVal != strb.wrData) &&
                     (pulsesOnAny(d) || (pulsesOnEnable(d) && strb.field == FLD_EN));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devSel           <= '0;
      reconfigurePulse <= '0;
      for (int d = 0; d < NUM_DEV; d++) begin
        enR[d]   <= defEnable(d);
        baseR[d] <= defBase(d);
        irqR[d]  <= defIrq(d);
        dmaR[d]  <= defDma(d);
      end
    end else begin
      reconfigurePulse <= pulseNext;
      if (strb.dataWr) begin
        case (strb.field)
          FLD_SEL: devSel               <= strb.wrData[SEL_W-1:0];
          FLD_EN:  enR[devSel]          <= strb.wrData;
          FLD_BHI: baseR[devSel][15:8]  <= strb.wrData;
          FLD_BLO: baseR[devSel][7:0]   <= strb.wrData;
          FLD_IRQ: irqR[devSel]         <= strb.wrData;
          FLD_DMA: dmaR[devSel]         <= strb.wrData;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : gFlat
    assign devActive[g]            = enR[g][0];
    assign devEnableFlat[8*g +: 8] = enR[g];
    assign devBaseFlat[16*g +: 16] = baseR[g];
    assign devIrqFlat[8*g +: 8]    = irqR[g];
    assign devDmaFlat[8*g +: 8]    = dmaR[g];
  end
endmodule

// File: rtl/pnp_ldev_bank.sv
module pnp_ldev_bank
  import pnp_bank_pkg::*;
#(
  parameter int NUM_DEV = 8
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgEnable,
  input  logic [15:0]            busAddr,
  input  logic [7:0]             busWrData,
  input  logic                   busWr,
  input  logic                   busRd,
  output logic [7:0]             busRdData,
  output logic [NUM_DEV-1:0]     devActive,
  output logic [8*NUM_DEV-1:0]   devEnableFlat,
  output logic [16*NUM_DEV-1:0]  devBaseFlat,
  output logic [8*NUM_DEV-1:0]   devIrqFlat,
  output logic [8*NUM_DEV-1:0]   devDmaFlat,
  output logic [NUM_DEV-1:0]     reconfigurePulse
);
  ctrlStrobeT strb;

  pnp_bank_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .busAddr(busAddr),
    .busWrData(busWrData), .busWr(busWr), .busRd(busRd), .strb(strb)
  );

  pnp_bank_dp #(.NUM_DEV(NUM_DEV)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busRdData(busRdData),
    .devActive(devActive), .devEnableFlat(devEnableFlat),
    .devBaseFlat(devBaseFlat), .devIrqFlat(devIrqFlat),
    .devDmaFlat(devDmaFlat), .reconfigurePulse(reconfigurePulse)
  );
endmodule

// File: rtl/pnp_ldev_bank_chk.sv
module pnp_ldev_bank_chk #(
  parameter int NUM_DEV = 8
)(
  input logic                  clk,
  input logic                  rstN,
  input logic                  cfgEnable,
  input logic [15:0]           busAddr,
  input logic                  busWr,
  input logic [7:0]            busRdData,
  input logic [8*NUM_DEV-1:0]  devEnableFlat,
  input logic [16*NUM_DEV-1:0] devBaseFlat,
  input logic [8*NUM_DEV-1:0]  devIrqFlat,
  input logic [8*NUM_DEV-1:0]  devDmaFlat,
  input logic [NUM_DEV-1:0]    reconfigurePulse
);
  assert_locked_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> busRdData == 8'hFF);

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgEnable) |-> ($stable(devBaseFlat) && $stable(devEnableFlat) && reconfigurePulse == '0));

  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reconfigurePulse != '0) |-> $past(busWr && cfgEnable && busAddr == 16'h0A79));

  assert_pulse_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reconfigurePulse));

  assert_fdc_enable_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    reconfigurePulse[0] |-> (!$stable(devEnableFlat[7:0]) && $stable(devBaseFlat[15:0])));

  assert_serial_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    reconfigurePulse[1] |-> (!$stable(devEnableFlat[15:8]) || !$stable(devBaseFlat[31:16]) ||
                             !$stable(devIrqFlat[15:8]) || !$stable(devDmaFlat[15:8])));
endmodule

bind pnp_ldev_bank pnp_ldev_bank_chk #(.NUM_DEV(NUM_DEV)) uChk (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .busAddr(busAddr),
  .busWr(busWr), .busRdData(busRdData), .devEnableFlat(devEnableFlat),
  .devBaseFlat(devBaseFlat), .devIrqFlat(devIrqFlat), .devDmaFlat(devDmaFlat),
  .reconfigurePulse(reconfigurePulse)
);

// File: tb/sim_pnp_ldev_bank.sv
`timescale 1ns/1ps
module sim_pnp_ldev_bank;
  localparam int N = 8;

  logic clk = 0, rstN = 0, cfgEnable = 1, busWr = 0, busRd = 0;
  logic [15:0] busAddr = 0;
  logic [7:0]  busWrData = 0;
  logic [7:0]  busRdData;
  logic [N-1:0] devActive, reconfigurePulse;
  logic [8*N-1:0] devEnableFlat, devIrqFlat, devDmaFlat;
  logic [16*N-1:0] devBaseFlat;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pnp_ldev_bank #(.NUM_DEV(N)) u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .busAddr(busAddr),
    .busWrData(busWrData), .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .devActive(devActive), .devEnableFlat(devEnableFlat), .devBaseFlat(devBaseFlat),
    .devIrqFlat(devIrqFlat), .devDmaFlat(devDmaFlat), .reconfigurePulse(reconfigurePulse)
  );

  // reference model
  logic [7:0]  mEn [N], mIrq [N], mDma [N];
  logic [15:0] mBase [N];
  logic [7:0]  mIdx;
  logic [2:0]  mSel;

  task automatic modelReset();
    mIdx = 0; mSel = 0;
    for (int d = 0; d < N; d++) begin
      mEn[d] = (d < 4) ? 8'h01 : 8'h00;
      mIrq[d] = 0; mDma[d] = 0; mBase[d] = 0;
    end
    mBase[0] = 16'h03F0; mIrq[0] = 6; mDma[0] = 2;
    mBase[1] = 16'h03F8; mIrq[1] = 4;
    mBase[2] = 16'h02F8; mIrq[2] = 3;
    mBase[3] = 16'h0378; mIrq[3] = 7;
  endtask

  function automatic logic [7:0] modelRead();
    case (mIdx)
      8'h07: return {5'b0, mSel};
      8'h30: return mEn[mSel];
      8'h60: return mBase[mSel][15:8];
      8'h61: return mBase[mSel][7:0];
      8'h70: return mIrq[mSel];
      8'h74: return mDma[mSel];
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [N-1:0] expPulse(input logic [7:0] v);
    logic known = (mIdx == 8'h30 || mIdx == 8'h60 || mIdx == 8'h61 || mIdx == 8'h70 || mIdx == 8'h74);
    logic [N-1:0] m = '0;
    if (known && modelRead() != v) begin
      if (mSel >= 1 && mSel <= 3) m[mSel] = 1'b1;
      if (mSel == 0 && mIdx == 8'h30) m[0] = 1'b1;
    end
    return m;
  endfunction

  task automatic modelWrite(input logic [7:0] v);
    case (mIdx)
      8'h07: mSel = v[2:0];
      8'h30: mEn[mSel] = v;
      8'h60: mBase[mSel][15:8] = v;
      8'h61: mBase[mSel][7:0] = v;
      8'h70: mIrq[mSel] = v;
      8'h74: mDma[mSel] = v;
      default: ;
    endcase
  endtask

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs();
    logic [8*N-1:0] eE, eI, eD;
    logic [16*N-1:0] eB;
    logic [N-1:0] eA;
    for (int d = 0; d < N; d++) begin
      eE[8*d +: 8] = mEn[d]; eI[8*d +: 8] = mIrq[d]; eD[8*d +: 8] = mDma[d];
      eB[16*d +: 16] = mBase[d]; eA[d] = mEn[d][0];
    end
    chk(devEnableFlat == eE, "R4 enable bus", devEnableFlat, eE);
    chk(devBaseFlat == eB,   "R4 base bus", devBaseFlat, eB);
    chk(devIrqFlat == eI,    "R4 irq bus", devIrqFlat, eI);
    chk(devDmaFlat == eD,    "R4 dma bus", devDmaFlat, eD);
    chk(devActive == eA,     "R10 active bits", devActive, eA);
    chk(busRdData == 8'hFF,  "R1 idle read data", busRdData, 8'hFF);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] v, input logic en, input string tag);
    logic [N-1:0] ep = '0;
    if (en && a == 16'h0A79) begin
      ep = expPulse(v);
      modelWrite(v);
    end else if (en && a == 16'h0279) mIdx = v;
    @(negedge clk);
    busAddr = a; busWrData = v; busWr = 1; cfgEnable = en;
    @(negedge clk);
    busWr = 0; cfgEnable = 1; busAddr = 0;
    chk(reconfigurePulse == ep, {tag, " pulse"}, reconfigurePulse, ep);
    @(negedge clk);
    chk(reconfigurePulse == '0, "R9 pulse one cycle", reconfigurePulse, 0);
    checkOutputs();
  endtask

  task automatic doRead(input logic [15:0] a, input logic en, input string tag);
    logic [7:0] e;
    e = (en && a == 16'h03E3) ? modelRead() : 8'hFF;
    @(negedge clk);
    busAddr = a; busRd = 1; cfgEnable = en;
    #1;
    chk(busRdData == e, tag, busRdData, e);
    busRd = 0; cfgEnable = 1; busAddr = 0;
  endtask

  task automatic setReg(input logic [7:0] idx, input logic [7:0] v, input string tag);
    doWrite(16'h0279, idx, 1, "R1 index");
    doWrite(16'h0A79, v, 1, tag);
  endtask

  initial begin
    #(10 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] picks [7];
    void'($urandom(32'h5EED_0C0F));
    picks = '{8'h07, 8'h30, 8'h60, 8'h61, 8'h70, 8'h74, 8'h00};
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R6 R11: reset state
    checkOutputs();
    doRead(16'h03E3, 1, "R11 index zero reads FF");
    doWrite(16'h0A79, 8'h5A, 1, "R11 write before index");
    doWrite(16'h0279, 8'h07, 1, "R1 index");
    doRead(16'h03E3, 1, "R11 selector resets zero");
    // R3 low bits only
    doWrite(16'h0A79, 8'hFD, 1, "R3 select");
    doRead(16'h03E3, 1, "R3 selector readback");
    // R9 game port: no pulse
    setReg(8'h30, 8'h01, "R9 game enable");
    doRead(16'h03E3, 1, "R4 game enable readback");
    // R8 floppy
    setReg(8'h07, 8'h00, "R3 select");
    setReg(8'h60, 8'h01, "R8 floppy base no pulse");
    setReg(8'h70, 8'h05, "R8 floppy irq no pulse");
    setReg(8'h30, 8'h00, "R8 floppy enable pulse");
    setReg(8'h30, 8'h00, "R8 floppy enable same");
    // R7 serial
    setReg(8'h07, 8'h01, "R3 select");
    setReg(8'h70, 8'h04, "R7 same value no pulse");
    setReg(8'h61, 8'hE8, "R7 base change pulse");
    doRead(16'h03E3, 1, "R4 base low readback");
    // R2 locked
    doWrite(16'h0A79, 8'h22, 0, "R2 locked data write");
    doWrite(16'h0279, 8'h74, 0, "R2 locked index write");
    doRead(16'h03E3, 0, "R2 locked read");
    doRead(16'h03E3, 1, "R2 index kept");
    // R1 stray addresses, R5 unknown register
    doWrite(16'h0A78, 8'h33, 1, "R1 stray write");
    doRead(16'h03E2, 1, "R1 stray read");
    setReg(8'h42, 8'h99, "R5 unknown write");
    doRead(16'h03E3, 1, "R5 unknown read");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r = $urandom % 10;
      if (r < 3) doWrite(16'h0279, picks[$urandom % 7], 1, "R1 index");
      else if (r < 6) begin
        logic [7:0] v = ($urandom % 3 == 0) ? modelRead() : 8'($urandom);
        doWrite(16'h0A79, v, 1, "R7 R8 R9 random write");
      end else if (r < 8) doRead(16'h03E3, 1, "R4 random read");
      else if (r < 9) doWrite(($urandom % 2) ? 16'h0A79 : 16'h0279, 8'($urandom), 0, "R2 random locked");
      else doRead(16'($urandom), 1, "R1 random address read");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule